// File: doc/BRIEF.md
# Flash Bus Write Qualifier

This block sits between the asynchronous strobe side of a parallel byte-wide flash bus and the command decoder inside the device. It runs on a fast internal clock and samples chip enable, write enable, output enable, address and data through a two-stage synchronizer. It then decides when a real write cycle has taken place. A write is present only while chip enable and write enable are both low and output enable is high. That combined strobe must hold a new level for a set number of clock cycles before the block treats the level as real, so short noise pulses on any of the three control lines are filtered out.

The address comes from the moment the combined strobe becomes active, which is the later of the two falling edges. The data comes from the moment it goes inactive, which is the earlier of the two rising edges. Each accepted write produces one single-cycle valid pulse carrying that address and data. A digital low-supply indication cancels all writes and drives a reset to the downstream command and program/erase logic. A write cycle that is already in progress when reset ends is refused. This power-up lock clears once chip enable or write enable has been seen high.

Top module: `flash_write_qualifier`

## Requirements
- R1: A write is accepted only when `bus_ce_n`=0, `bus_we_n`=0 and `bus_oe_n`=1 together. Any of the other seven level combinations, held for any length of time, produces no `wr_valid` pulse.
- R2: The combined strobe must be active for at least `FILT_CYC` consecutive clock cycles to start a write. A shorter active pulse produces no write.
- R3: While a write is in progress, an inactive gap shorter than `FILT_CYC` cycles does not end the write, and exactly one pulse results. A gap of `FILT_CYC` cycles or more ends the write, and a second write follows if the strobe becomes active again.
- R4: `wr_addr` carries the address present when the second of chip enable and write enable fell. Address changes after that point have no effect.
- R5: `wr_data` carries the data present when the first of chip enable and write enable rose. Data changes after that point have no effect.
- R6: `cmd_reset` follows `supply_low` with a latency of two clock edges. While it is high, no `wr_valid` pulse is produced.
- R7: If `supply_low` is asserted at any time during a write cycle, that cycle produces no pulse, even if `supply_low` drops again before the strobe is released.
- R8: If chip enable and write enable are both low when reset ends, the write cycle that follows produces no pulse. Once chip enable or write enable has been seen high, writes are accepted normally.
- R9: Each accepted write gives exactly one `wr_valid` cycle, due `FILT_CYC`+2 clock edges after the strobe release is driven. `wr_addr` and `wr_data` change only in a `wr_valid` cycle.
- R10: During reset, `wr_valid`, `cmd_reset`, `wr_addr` and `wr_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable from the bus, active low |
| bus_we_n | input | 1 | Write enable from the bus, active low |
| bus_oe_n | input | 1 | Output enable from the bus, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| supply_low | input | 1 | Low-supply indication, high while the supply is below the lockout level |
| wr_valid | output | 1 | One-cycle pulse for each accepted write |
| wr_addr | output | ADDR_W | Latched address of the last accepted write |
| wr_data | output | DATA_W | Latched data of the last accepted write |
| cmd_reset | output | 1 | Reset to the command and program/erase logic |

## Verification
Every bus input passes through two synchronizer flops. `cmd_reset` therefore shows a change of `supply_low` on the second clock edge after it is driven. A write pulse shows up `FILT_CYC`+2 edges after the release, that is two synchronizer edges plus `FILT_CYC` filter edges. The bench drives inputs on the falling clock edge and samples on falling edges. It counts edges from the release to check the pulse position exactly, and it checks `cmd_reset` one edge before and on the edge it is due. Tests where no write should occur wait 12 cycles, well past the latest possible pulse, before they compare pulse counts. A free-running monitor counts every pulse, so a late or spurious pulse is always caught.

// File: rtl/fwq_pkg.sv
// Package: shared constants for the flash bus write qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package fwq_pkg;
    // Number of flops in each input synchronizer chain.
    localparam int SYNC_STAGES = 2;
    // Bit positions of the control lines inside the synchronized strobe vector.
    localparam int CTL_CE = 0;
    localparam int CTL_WE = 1;
    localparam int CTL_OE = 2;
    localparam int CTL_W  = 3;
endpackage

// File: rtl/fwq_sync.sv
// Module: fwq_sync
// A multi-flop chain that brings an asynchronous vector into the clock
// domain. When it carries address or data, it also acts as a matching delay line.
// Assumes: each bit is treated on its own; bus values are stable around the
// strobe edges, so the address and data lines need no handshake.
module fwq_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= d;
                end
            end else begin : g_next
                // Move the value one stage along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fwq_filter.sv
// Module: fwq_filter
// A two-way debounce on the combined write strobe. The filtered level
// follows the raw level only after the raw level has differed from it for
// FILT_CYC cycles in a row. The module also reports the raw edges and the
// coming filtered transitions.
// Assumes: FILT_CYC >= 2.
module fwq_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt,
    output logic raw_on,
    output logic raw_off,
    output logic go_active,
    output logic go_idle
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt;
    logic          raw_q;
    logic          flip;

    // Flip happens on the next edge when the mismatch reaches its last cycle.
    assign flip      = (raw != filt) && (cnt == LAST);
    assign go_active = flip && raw;
    assign go_idle   = flip && !raw;
    assign raw_on    = raw && !raw_q;
    assign raw_off   = !raw && raw_q;

    // Remember the previous raw level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw;
    end

    // Count mismatch cycles and move the filtered level once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (flip) begin
            cnt  <= '0;
            filt <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwq_inhibit.sv
// Module: fwq_inhibit
// The write lockouts. It holds the power-up block until chip enable or
// write enable is seen high, passes the synchronized low-supply flag out
// as the downstream reset, and says whether a new write may be armed.
// Assumes: the control inputs are already synchronized.
module fwq_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic we_n_s,
    input  logic low_s,
    output logic pu_block,
    output logic cmd_reset,
    output logic arm_ok
);
    // Set by reset; cleared for good once either strobe line is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)                pu_block <= 1'b1;
        else if (ce_n_s || we_n_s) pu_block <= 1'b0;
    end

    assign cmd_reset = low_s;
    assign arm_ok    = !pu_block && !low_s;
endmodule

// File: rtl/fwq_capture.sv
// Module: fwq_capture
// Holds the candidate address and data. The address is taken when the raw
// strobe becomes active and the data when it goes inactive. The cycle is
// armed when the filtered strobe asserts, and the write is issued when the
// filtered strobe releases.
// Assumes: the filter reports go_idle at least one cycle after raw_off.
module fwq_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              filt,
    input  logic              raw_on,
    input  logic              raw_off,
    input  logic              go_active,
    input  logic              go_idle,
    input  logic              arm_ok,
    input  logic              low_s,
    output logic              armed,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [ADDR_W-1:0] cand_addr;
    logic [DATA_W-1:0] cand_data;
    logic              accept;

    assign accept = go_idle && armed && !low_s;

    // The address is taken at the later falling edge, the data at the earlier rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_addr <= '0;
            cand_data <= '0;
        end else begin
            if (raw_on && !filt) cand_addr <= addr_s;
            if (raw_off && filt) cand_data <= data_s;
        end
    end

    // Arm at the filtered start; drop on low supply or at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (go_active) armed <= arm_ok;
        else if (low_s)     armed <= 1'b0;
        else if (go_idle)   armed <= 1'b0;
    end

    // Issue the one-cycle pulse and update the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= accept;
            if (accept) begin
                wr_addr <= cand_addr;
                wr_data <= cand_data;
            end
        end
    end
endmodule

// File: rtl/flash_write_qualifier.sv
// Module: flash_write_qualifier (top)
// Turns asynchronous flash bus strobes into one-cycle write pulses that
// carry the latched address and data. Glitches are filtered, and the
// power-up and low-supply lockouts are applied.
// Assumes: clk is much faster than the bus cycle; FILT_CYC >= 2.
module flash_write_qualifier #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int FILT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              supply_low,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_reset
);
    import fwq_pkg::*;

    localparam int BUS_W = ADDR_W + DATA_W;

    logic [CTL_W-1:0] ctl_s;
    logic [BUS_W-1:0] bus_s;
    logic             low_s;
    logic             raw_s;
    logic             filt, raw_on, raw_off, go_active, go_idle;
    logic             pu_block, arm_ok, armed;

    // Control lines reset to "low" so that no strobe is seen high before real samples arrive.
    fwq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_oe_n, bus_we_n, bus_ce_n}), .q(ctl_s)
    );

    fwq_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_data}), .q(bus_s)
    );

    fwq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_low_sync (
        .clk(clk), .rst_n(rst_n), .d(supply_low), .q(low_s)
    );

    // The combined strobe: both enables low and the output enable high.
    assign raw_s = !ctl_s[CTL_CE] && !ctl_s[CTL_WE] && ctl_s[CTL_OE];

    fwq_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .raw(raw_s), .filt(filt),
        .raw_on(raw_on), .raw_off(raw_off),
        .go_active(go_active), .go_idle(go_idle)
    );

    fwq_inhibit u_inhibit (
        .clk(clk), .rst_n(rst_n),
        .ce_n_s(ctl_s[CTL_CE]), .we_n_s(ctl_s[CTL_WE]), .low_s(low_s),
        .pu_block(pu_block), .cmd_reset(cmd_reset), .arm_ok(arm_ok)
    );

    fwq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .addr_s(bus_s[BUS_W-1:DATA_W]), .data_s(bus_s[DATA_W-1:0]),
        .filt(filt), .raw_on(raw_on), .raw_off(raw_off),
        .go_active(go_active), .go_idle(go_idle),
        .arm_ok(arm_ok), .low_s(low_s), .armed(armed),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Elaboration-time guard on the filter length.
    initial begin
        if (FILT_CYC < 2) $error("FILT_CYC must be at least 2");
    end
endmodule

// File: rtl/fwq_checker.sv
// Module: fwq_checker
// Timing properties of the write qualifier, attached to the top module with bind.
module fwq_checker #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              cmd_reset,
    input logic              pu_block,
    input logic              armed,
    input logic              raw_s,
    input logic              filt
);
    // R9: a write pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R9: the output registers change only together with a pulse
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wr_addr) || !$stable(wr_data)) |-> wr_valid);

    // R6: no pulse directly after a cycle with the downstream reset high
    a_r6_no_write_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_reset) |-> !wr_valid);

    // R8: arming is refused while the power-up block or low supply is in force
    a_r8_arm_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> (!$past(pu_block) && !$past(cmd_reset)));

    // R2: the filtered strobe rises only after the raw strobe has been active for more than one cycle
    a_r2_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt) |-> ($past(raw_s) && $past(raw_s, 2)));
endmodule

bind flash_write_qualifier fwq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwq_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_reset(cmd_reset), .pu_block(pu_block),
    .armed(armed), .raw_s(raw_s), .filt(filt)
);

// File: tb/flash_write_qualifier_tb_top.sv
`timescale 1ns/1ps
module flash_write_qualifier_tb_top;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int FILT = 4;
    localparam int LAT  = FILT + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          wr_valid, cmd_reset;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, failures = 0, n_wr = 0;
    logic [AW-1:0] last_a = '0;
    logic [DW-1:0] last_d = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_write_qualifier #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
        .bus_oe_n(oe_n), .bus_addr(addr), .bus_data(data), .supply_low(low),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_reset(cmd_reset)
    );

    // Pulse monitor: counts every write and records what it carried.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            n_wr   <= n_wr + 1;
            last_a <= wr_addr;
            last_d <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
        @(negedge clk);
        addr = a; data = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        cyc(hold);
        bus_idle();
        cyc(12);
    endtask

    initial begin
        int n0;
        int k;
        cyc(3);
        // R10: reset state
        chk(wr_valid == 0 && cmd_reset == 0, "R10 reset pulse/reset", wr_valid, 0);
        chk(wr_addr == 0 && wr_data == 0, "R10 reset regs", wr_addr, 0);
        rst_n = 1'b1;
        cyc(5);

        // R1, R9: sweep of ordinary writes
        for (int i = 0; i < 16; i++) begin
            n0 = n_wr;
            wr_cycle(AW'(i * 17), DW'(i * 29 + 3), 6);
            chk(n_wr == n0 + 1, "R1 write count", n_wr - n0, 1);
            chk(last_a == AW'(i * 17), "R1 addr", last_a, i * 17 % 256);
            chk(last_d == DW'(i * 29 + 3), "R1 data", last_d, (i * 29 + 3) % 256);
        end

        // R2: sweep of active pulse lengths
        for (int len = 1; len <= 2 * FILT; len++) begin
            n0 = n_wr;
            wr_cycle(8'h40, 8'h11, len);
            chk(n_wr - n0 == ((len >= FILT) ? 1 : 0), "R2 min width", n_wr - n0, (len >= FILT) ? 1 : 0);
        end

        // R1: all eight control combinations
        for (int c = 0; c < 8; c++) begin
            n0 = n_wr;
            @(negedge clk);
            ce_n = c[2]; we_n = c[1]; oe_n = c[0];
            cyc(10);
            bus_idle();
            cyc(12);
            chk(n_wr - n0 == ((c == 1) ? 1 : 0), "R1 combination", n_wr - n0, (c == 1) ? 1 : 0);
        end

        // R3: inactive gaps in the middle of a write
        for (int g = 1; g <= FILT; g++) begin
            n0 = n_wr;
            @(negedge clk);
            addr = 8'h55; data = 8'hA1; ce_n = 0; we_n = 0; oe_n = 1;
            cyc(8);
            we_n = 1'b1;
            cyc(g);
            we_n = 1'b0;
            cyc(2);
            data = 8'hA3;
            cyc(6);
            bus_idle();
            cyc(12);
            chk(n_wr - n0 == ((g >= FILT) ? 2 : 1), "R3 gap", n_wr - n0, (g >= FILT) ? 2 : 1);
            chk(last_d == 8'hA3, "R3 final data", last_d, 8'hA3);
        end

        // R4: address from the later falling edge, CE first then WE
        @(negedge clk);
        addr = 8'h21; ce_n = 0; oe_n = 1;
        cyc(6);
        addr = 8'h22; we_n = 0;
        cyc(3);
        addr = 8'h23;
        cyc(6);
        bus_idle();
        cyc(12);
        chk(last_a == 8'h22, "R4 ce first", last_a, 8'h22);
        // R4: WE first then CE
        @(negedge clk);
        addr = 8'h31; we_n = 0;
        cyc(6);
        addr = 8'h32; ce_n = 0;
        cyc(3);
        addr = 8'h33;
        cyc(6);
        bus_idle();
        cyc(12);
        chk(last_a == 8'h32, "R4 we first", last_a, 8'h32);

        // R5: data from the earlier rising edge, WE rises first
        @(negedge clk);
        data = 8'hD1; ce_n = 0; we_n = 0;
        cyc(8);
        we_n = 1'b1;
        cyc(1);
        data = 8'hD2;
        cyc(6);
        ce_n = 1'b1;
        cyc(12);
        chk(last_d == 8'hD1, "R5 we first", last_d, 8'hD1);
        // R5: CE rises first
        @(negedge clk);
        data = 8'hE1; ce_n = 0; we_n = 0;
        cyc(8);
        ce_n = 1'b1;
        cyc(1);
        data = 8'hE2;
        cyc(6);
        we_n = 1'b1;
        cyc(12);
        chk(last_d == 8'hE1, "R5 ce first", last_d, 8'hE1);

        // R9: exact pulse position and width
        @(negedge clk);
        addr = 8'h77; data = 8'h99; ce_n = 0; we_n = 0;
        cyc(8);
        bus_idle();
        k = 0;
        while (k < 20) begin
            @(negedge clk);
            k++;
            if (wr_valid) break;
        end
        chk(k == LAT, "R9 latency", k, LAT);
        @(negedge clk);
        chk(wr_valid == 0, "R9 one cycle", wr_valid, 0);
        cyc(10);

        // R6: cmd_reset latency and write suppression
        @(negedge clk);
        low = 1'b1;
        @(negedge clk);
        chk(cmd_reset == 0, "R6 before due", cmd_reset, 0);
        @(negedge clk);
        chk(cmd_reset == 1, "R6 due", cmd_reset, 1);
        n0 = n_wr;
        wr_cycle(8'h12, 8'h34, 8);
        chk(n_wr == n0, "R6 no write", n_wr - n0, 0);
        chk(cmd_reset == 1, "R6 held", cmd_reset, 1);
        low = 1'b0;
        cyc(3);
        chk(cmd_reset == 0, "R6 released", cmd_reset, 0);

        // R7: short low-supply blip during a cycle cancels it
        n0 = n_wr;
        @(negedge clk);
        addr = 8'h44; data = 8'h45; ce_n = 0; we_n = 0;
        cyc(8);
        low = 1'b1;
        cyc(3);
        low = 1'b0;
        cyc(6);
        bus_idle();
        cyc(12);
        chk(n_wr == n0, "R7 cancelled", n_wr - n0, 0);
        wr_cycle(8'h46, 8'h47, 6);
        chk(n_wr == n0 + 1 && last_a == 8'h46, "R7 recovers", n_wr - n0, 1);

        // R8: strobe already active when reset ends
        @(negedge clk);
        rst_n = 1'b0; ce_n = 0; we_n = 0; oe_n = 1; addr = 8'h66; data = 8'h67;
        cyc(4);
        rst_n = 1'b1;
        n0 = 0;
        cyc(1);
        n0 = n_wr;
        cyc(10);
        we_n = 1'b1;
        cyc(12);
        chk(n_wr == n0, "R8 power-up write refused", n_wr - n0, 0);
        ce_n = 1'b1;
        cyc(2);
        wr_cycle(8'h68, 8'h69, 6);
        chk(n_wr == n0 + 1 && last_d == 8'h69, "R8 later write accepted", n_wr - n0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule